// File: doc/BRIEF.md
# Serial Configuration Receiver with Holding Latch

This block is the device-side end of a three-wire configuration port. An external controller presents a serial clock, a data line and a load strobe. The block brings all three into the system clock domain, shifts one data bit per serial-clock rising edge into a 24-bit shift register, and copies that register into a holding latch when the strobe goes high. The latch drives the configuration fields of a frequency synthesizer as plain output ports. Those fields are:

- the reference divide word
- the VCO divide word
- the output divide select
- the secondary-output mode
- the duty-cycle trim bit
- the crystal load-capacitance code

While the strobe is held high, the latch is transparent to the shifter. Every shifted word then passes straight to the outputs. Reset loads a default word that gives an overall ratio of one. A flag marks any latched word whose divider values the synthesizer cannot accept, but such a word is still latched. A one-cycle pulse marks every change of the latch contents.

Top module: `cfgport_rx`

## Requirements
- R1: While reset is high and after it, until the first load, the latch holds 0x230406. That word decodes as reference word 6, VCO word 8, divide select 3'b011, secondary mode 2'b00, duty bit 1, capacitance code 2'b00. `illegal_o` and `updated_o` are low.
- R2: Each rising edge of the synchronized serial clock shifts the synchronized data bit in at the LSB. After 24 such edges, the first bit sent sits in bit 23.
- R3: Fields of the 24-bit word are decoded as follows: cap code = bits 23:22, duty bit = bit 21, secondary mode = bits 20:19, divide select = bits 18:16, VCO word = bits 15:7, reference word = bits 6:0. As an example, loading 0x318A3B gives reference 59, VCO 276, select 1, mode 2, duty 1, cap 0.
- R4: A rising edge of the synchronized strobe copies the shift register into the latch. While the strobe is low, shifting leaves every latched output unchanged.
- R5: While the synchronized strobe is high, every serial-clock edge also loads the newly shifted word into the latch, in the same cycle as the shift.
- R6: `illegal_o` is high exactly when the latched VCO word is below 4 or the latched reference word is 0. An illegal word is still latched. VCO 4 with reference 1 is legal.
- R7: `updated_o` pulses high for one cycle in the same cycle that the latch contents change. Reloading an identical word gives no pulse.
- R8: The latched outputs change on the third system-clock edge after a pin edge: two synchronizer stages, then the register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Asynchronous serial shift clock |
| data_i | input | 1 | Asynchronous serial data |
| strobe_i | input | 1 | Asynchronous load strobe |
| ref_div_o | output | 7 | Latched reference divide word |
| vco_div_o | output | 9 | Latched VCO divide word |
| out_sel_o | output | 3 | Latched output divide select |
| clk2_sel_o | output | 2 | Latched secondary-output mode |
| duty_o | output | 1 | Latched duty-cycle trim bit |
| cap_o | output | 2 | Latched load-capacitance code |
| illegal_o | output | 1 | Latched word holds an unusable divider value |
| updated_o | output | 1 | One-cycle pulse on a latch change |

## Verification
The bench targets the bit order and field slicing with a known word. A design that shifted LSB-first, or that sliced the VCO field one position off, would show wrong reference or VCO values. It holds the strobe high and shifts single bits: a design without transparency would freeze the outputs, and one that latched the pre-shift value would lag by one bit. It places divider words at the edges of the legal ranges (VCO 3 and 4, reference 0 and 1) to catch an off-by-one comparison, and it reloads an identical word, where a design pulsing on every load rather than on a change would emit a spurious update. A behavioural per-cycle model also catches any extra or missing synchronizer stage as a one-cycle timing mismatch.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int WORD_W      = 24;
    localparam int REF_W       = 7;
    localparam int VCO_W       = 9;
    localparam int SEL_W       = 3;
    localparam int MODE_W      = 2;
    localparam int CAP_W       = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [VCO_W-1:0] VCO_MIN = VCO_W'(4);
    localparam logic [REF_W-1:0] REF_MIN = REF_W'(1);

    typedef enum logic [MODE_W-1:0] {
        MODE_REF      = 2'b00,
        MODE_REF_HALF = 2'b01,
        MODE_OFF      = 2'b10,
        MODE_OUT_HALF = 2'b11
    } clk2_mode_e;

    typedef struct packed {
        logic [CAP_W-1:0] cap;
        logic             duty;
        clk2_mode_e       mode;
        logic [SEL_W-1:0] out_sel;
        logic [VCO_W-1:0] vco;
        logic [REF_W-1:0] refd;
    } cfg_word_t;

    localparam cfg_word_t CFG_DEFAULT = cfg_word_t'(24'h230406);

    function automatic logic word_illegal(input cfg_word_t w);
        return (w.vco < VCO_MIN) || (w.refd < REF_MIN);
    endfunction

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfgport_edge.sv
module cfgport_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/cfgport_shifter.sv
module cfgport_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] shift_q,
    output logic [W-1:0] shift_next
);
    always_comb begin
        shift_next = shift_q;
        if (shift_en) shift_next = {shift_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= shift_next;
    end
endmodule

// File: rtl/cfgport_latch.sv
module cfgport_latch
    import cfgport_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cfg_word_t din,
    output cfg_word_t word_q,
    output logic      updated_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q    <= CFG_DEFAULT;
            updated_q <= 1'b0;
        end else begin
            updated_q <= load && (din != word_q);
            if (load) word_q <= din;
        end
    end
endmodule

// File: rtl/cfgport_rx.sv
module cfgport_rx
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              data_i,
    input  logic              strobe_i,
    output logic [REF_W-1:0]  ref_div_o,
    output logic [VCO_W-1:0]  vco_div_o,
    output logic [SEL_W-1:0]  out_sel_o,
    output logic [MODE_W-1:0] clk2_sel_o,
    output logic              duty_o,
    output logic [CAP_W-1:0]  cap_o,
    output logic              illegal_o,
    output logic              updated_o
);
    localparam int NPIN = 3;

    logic [NPIN-1:0]   pins_s;
    logic              sclk_s, data_s, strobe_s;
    logic [1:0]        rise;
    logic              sclk_rise, strobe_rise;
    logic [WORD_W-1:0] shift_q, shift_next;
    logic              load;
    cfg_word_t         word_q;

    cfgport_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i({strobe_i, data_i, sclk_i}),
        .sync_o (pins_s)
    );

    assign sclk_s   = pins_s[0];
    assign data_s   = pins_s[1];
    assign strobe_s = pins_s[2];

    cfgport_edge #(.WIDTH(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .level_i({strobe_s, sclk_s}),
        .rise_o (rise)
    );

    assign sclk_rise   = rise[0];
    assign strobe_rise = rise[1];

    cfgport_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (sclk_rise),
        .bit_in    (data_s),
        .shift_q   (shift_q),
        .shift_next(shift_next)
    );

    // Load on a strobe edge, or on every shift while the strobe is held high.
    assign load = strobe_rise || (strobe_s && sclk_rise);

    cfgport_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .din      (cfg_word_t'(shift_next)),
        .word_q   (word_q),
        .updated_q(updated_o)
    );

    assign ref_div_o  = word_q.refd;
    assign vco_div_o  = word_q.vco;
    assign out_sel_o  = word_q.out_sel;
    assign clk2_sel_o = word_q.mode;
    assign duty_o     = word_q.duty;
    assign cap_o      = word_q.cap;
    assign illegal_o  = word_illegal(word_q);
endmodule

// File: rtl/cfgport_rx_chk.sv
module cfgport_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic [23:0] word_i,
    input logic [23:0] shift_i,
    input logic        strobe_s_i,
    input logic        sclk_rise_i,
    input logic        illegal_i,
    input logic        updated_i
);
    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    // R1
    reset_default_chk: assert property (@(posedge clk)
        (seen_q && $past(rst)) |-> (word_i == 24'h230406));

    // R4
    load_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (word_i != $past(word_i)) |-> $past(strobe_s_i));

    // R5
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(strobe_s_i) && $past(sclk_rise_i)) |-> (word_i == shift_i));

    // R6
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_i |-> ((word_i[15:7] < 9'd4) || (word_i[6:0] == 7'd0)));

    // R7
    update_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        (word_i != $past(word_i)) |-> updated_i);

    // R7
    update_single_chk: assert property (@(posedge clk) disable iff (rst)
        updated_i |=> !updated_i);
endmodule

bind cfgport_rx cfgport_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_i     ({cap_o, duty_o, clk2_sel_o, out_sel_o, vco_div_o, ref_div_o}),
    .shift_i    (shift_q),
    .strobe_s_i (strobe_s),
    .sclk_rise_i(sclk_rise),
    .illegal_i  (illegal_o),
    .updated_i  (updated_o)
);

// File: tb/test_cfgport_rx.sv
module test_cfgport_rx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_i = 1'b0, data_i = 1'b0, strobe_i = 1'b0;
    logic [6:0] ref_div_o;
    logic [8:0] vco_div_o;
    logic [2:0] out_sel_o;
    logic [1:0] clk2_sel_o;
    logic       duty_o;
    logic [1:0] cap_o;
    logic       illegal_o, updated_o;

    int n_tests = 0;
    int n_fail  = 0;
    int upd_cnt = 0;

    always #5 clk = ~clk;

    cfgport_rx i_cfgport_rx (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .data_i(data_i), .strobe_i(strobe_i),
        .ref_div_o(ref_div_o), .vco_div_o(vco_div_o), .out_sel_o(out_sel_o),
        .clk2_sel_o(clk2_sel_o), .duty_o(duty_o), .cap_o(cap_o),
        .illegal_o(illegal_o), .updated_o(updated_o)
    );

    logic [23:0] out_word;
    assign out_word = {cap_o, duty_o, clk2_sel_o, out_sel_o, vco_div_o, ref_div_o};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference: pins seen through a two-cycle delay, edge found
    // against the value one cycle older still.
    int h_s[4], h_d[4], h_t[4];
    int m_shift = 0;
    int m_latch = 'h230406;
    int m_upd   = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_shift = 0; m_latch = 'h230406; m_upd = 0;
            for (int i = 0; i < 4; i++) begin h_s[i] = 0; h_d[i] = 0; h_t[i] = 0; end
        end else begin
            int nxt;
            bit ld;
            nxt = m_shift;
            if (h_s[2] == 1 && h_s[3] == 0) nxt = ((m_shift << 1) | h_d[2]) & 'hFFFFFF;
            ld = (h_t[2] == 1 && h_t[3] == 0) || (h_t[2] == 1 && h_s[2] == 1 && h_s[3] == 0);
            m_upd = (ld && nxt != m_latch) ? 1 : 0;
            if (ld) m_latch = nxt;
            m_shift = nxt;
            for (int i = 3; i > 1; i--) begin h_s[i] = h_s[i-1]; h_d[i] = h_d[i-1]; h_t[i] = h_t[i-1]; end
            h_s[1] = sclk_i; h_d[1] = data_i; h_t[1] = strobe_i;
            for (int i = 3; i > 1; i--) ; // history already advanced
        end
    end

    // Compare every cycle (R8 timing, plus R6/R7 flags)
    always @(negedge clk) begin
        if (!rst) begin
            int v, r;
            v = (m_latch >> 7) & 'h1FF;
            r = m_latch & 'h7F;
            check("R8 model word", {8'd0, out_word}, m_latch);
            check("R6 model illegal", {31'd0, illegal_o}, (v < 4 || r == 0) ? 1 : 0);
            check("R7 model updated", {31'd0, updated_o}, m_upd);
            if (updated_o) upd_cnt++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        data_i = b; sclk_i = 1'b0; cycles(3);
        sclk_i = 1'b1; cycles(3);
        sclk_i = 1'b0;
    endtask

    task automatic send_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
        cycles(4);
    endtask

    task automatic pulse_strobe();
        strobe_i = 1'b1; cycles(4);
        strobe_i = 1'b0; cycles(4);
    endtask

    function automatic logic [23:0] mk(input logic [8:0] v, input logic [6:0] r);
        return {2'b01, 1'b0, 2'b11, 3'b101, v, r};
    endfunction

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cycles(4);
        // R1: reset values
        check("R1 ref", ref_div_o, 6);
        check("R1 vco", vco_div_o, 8);
        check("R1 sel", out_sel_o, 3);
        check("R1 mode", clk2_sel_o, 0);
        check("R1 duty", duty_o, 1);
        check("R1 illegal", illegal_o, 0);
        rst = 1'b0;
        cycles(3);
        check("R1 after release", out_word, 24'h230406);

        // R4: shifting with strobe low leaves outputs alone
        send_word(24'h318A3B);
        check("R4 no load without strobe", out_word, 24'h230406);

        // R2/R3: known word fields after strobe
        upd_cnt = 0;
        pulse_strobe();
        check("R2 full word MSB first", out_word, 24'h318A3B);
        check("R3 ref", ref_div_o, 59);
        check("R3 vco", vco_div_o, 276);
        check("R3 sel", out_sel_o, 1);
        check("R3 mode", clk2_sel_o, 2);
        check("R3 duty", duty_o, 1);
        check("R3 cap", cap_o, 0);
        check("R7 one pulse on change", upd_cnt, 1);

        // R7: same word again, no pulse
        upd_cnt = 0;
        send_word(24'h318A3B);
        pulse_strobe();
        check("R7 no pulse on identical reload", upd_cnt, 0);

        // R6: boundaries
        send_word(mk(9'd3, 7'd5)); pulse_strobe();
        check("R6 vco 3 latched", vco_div_o, 3);
        check("R6 vco 3 illegal", illegal_o, 1);
        send_word(mk(9'd100, 7'd0)); pulse_strobe();
        check("R6 ref 0 latched", ref_div_o, 0);
        check("R6 ref 0 illegal", illegal_o, 1);
        send_word(mk(9'd4, 7'd1)); pulse_strobe();
        check("R6 vco 4 ref 1 legal", illegal_o, 0);

        // R5: transparent while strobe high
        send_word(24'h5A5A5A);
        strobe_i = 1'b1; cycles(4);
        check("R5 strobe edge load", out_word, 24'h5A5A5A);
        send_bit(1'b1); cycles(3);
        check("R5 follows shift 1", out_word, 24'hB4B4B5);
        send_bit(1'b0); cycles(3);
        check("R5 follows shift 2", out_word, 24'h69696A);
        strobe_i = 1'b0; cycles(4);
        send_bit(1'b1); cycles(4);
        check("R4 frozen after strobe low", out_word, 24'h69696A);

        // R1: reset again mid-run
        rst = 1'b1; cycles(3);
        check("R1 reset mid-run", out_word, 24'h230406);
        rst = 1'b0; cycles(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule